// File: doc/BRIEF.md
# Oversampling Asynchronous Character Receiver

This block is the receive half of an asynchronous serial adapter. It watches a serial input line on every rising edge of its receive clock, locates the start of each character, and shifts in the data bits. It then checks parity and the stop bit and hands the finished character to a single holding register. The host reads that register. The line can be sampled once per bit, with timing supplied from outside, or oversampled at one of two configurable ratios (16 and 64 by default). When oversampling, a start bit only counts after half a bit time of continuous low samples.

The host sees a full flag, framing and parity flags that belong to the held character, a deferred overrun flag and the data byte. A read strobe empties the register. A carrier-loss input holds the receiver initialized for as long as it is high. Selecting the fourth value of the divider field acts as a master reset of the receiver status. Bus decoding and interrupt generation live outside this block.

Top module: `async_rx_engine`

## Requirements
- R1: With `div_sel` = 2'b00 every rising clock edge is one bit time: a low sample in idle is the start bit, and the following edges sample the data bits, the parity bit if any, and then the stop bit.
- R2: With `div_sel` = 2'b01 (ratio DIV_A) or 2'b10 (ratio DIV_B), bit timing locks only after DIV/2 consecutive low samples. A low pulse shorter than that is dropped and produces no character.
- R3: When oversampling, each later bit is sampled once, DIV clocks after the previous sample point, so the samples fall in the middle of each bit.
- R4: `fmt_sel` picks the format. 000 is 7 data bits with even parity, 001 is 7 odd, 010 is 7 even, 011 is 7 odd, 100 and 101 are 8 data bits without parity, 110 is 8 even and 111 is 8 odd. Bits arrive least significant first, the parity bit follows the last data bit, and only one stop bit is checked. Even parity means the data bits and the parity bit together hold an even number of ones; odd parity means an odd number. A mismatch sets `parity_err`.
- R5: In the 7-bit formats, `rx_data[7]` is delivered as 0.
- R6: `frame_err` is set when the stop bit is sampled low.
- R7: `frame_err` and `parity_err` change only when a character is loaded, and they keep their values for as long as that character is held.
- R8: A finished character loads only into an empty register, and the load sets `rx_full`. A one-cycle `data_rd` clears `rx_full` and leaves `rx_data` unchanged.
- R9: If a character finishes while the register is full, it is dropped and an overrun is recorded, but `overrun` stays low. The next `data_rd` returns the older character, raises `overrun` and keeps `rx_full` high.
- R10: The `data_rd` after that clears both `overrun` and `rx_full`. Characters received afterwards load normally. A master reset also clears `overrun`.
- R11: While `carrier_lost` is high, the receiver stays initialized: `rx_full` and `overrun` read 0 and no character is assembled.
- R12: `rst_n` low (synchronous) or `div_sel` = 2'b11 clears `rx_full`, `overrun`, `frame_err` and `parity_err`.
- R13: For the formats without parity, `parity_err` is 0 on load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Serial receive line, idle high |
| carrier_lost | input | 1 | High holds the receiver initialized |
| div_sel | input | 2 | 00 ratio 1, 01 DIV_A, 10 DIV_B, 11 master reset |
| fmt_sel | input | 3 | Character format select (see R4) |
| data_rd | input | 1 | One-cycle strobe: host reads the data register |
| rx_data | output | 8 | Held character |
| rx_full | output | 1 | Held character not yet read |
| frame_err | output | 1 | Stop bit of the held character was low |
| parity_err | output | 1 | Parity of the held character was wrong |
| overrun | output | 1 | A character was lost (deferred report) |

## Verification
The assertions assume that `div_sel` and `fmt_sel` change only while no character is in progress, and that `data_rd` is a single-cycle pulse. If the ratio changed in mid-character, the tick spacing and the qualification properties would break. The directed stimulus changes the configuration only between whole frames, after the line has been idle. It drives the line and the strobes on the falling clock edge. Framing-error frames hold the low stop level only just past its sample point, so that the tail of a bad stop bit cannot be taken for a new start bit.

// File: rtl/async_rx_pkg.sv
// Package: shared state type and format decode helpers for the receiver.
// Assumes the fixed eight-entry format code of the receiver (bit 2 = 8 data bits).
package async_rx_pkg;

    localparam int CHAR_W  = 8;
    localparam int SHIFT_W = CHAR_W + 1;

    typedef enum logic [1:0] {
        SMP_IDLE = 2'd0,
        SMP_QUAL = 2'd1,
        SMP_RUN  = 2'd2
    } smp_state_t;

    // True when the format carries eight data bits.
    function automatic logic fmt_eight(input logic [2:0] f);
        return f[2];
    endfunction

    // True when the format carries a parity bit (codes 100 and 101 do not).
    function automatic logic fmt_parity(input logic [2:0] f);
        return !(f[2] && !f[1]);
    endfunction

    // True when odd parity is selected.
    function automatic logic fmt_odd(input logic [2:0] f);
        return f[0];
    endfunction

endpackage

// File: rtl/rx_bit_sampler.sv
// Module: rx_bit_sampler
// Finds start bits and produces one tick per bit at the sample point.
// Ratio 1: any low sample in idle is a start bit; ticks every clock afterwards.
// Ratio DIV_A/DIV_B: needs DIV/2 consecutive lows, then ticks every DIV clocks.
// Assumes div_sel is stable while a character is in progress.
module rx_bit_sampler
    import async_rx_pkg::*;
#(
    parameter int DIV_A = 16,
    parameter int DIV_B = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [1:0] div_sel,
    input  logic       rx_line,
    input  logic       frame_done,
    output logic       tick_o,
    output logic       run_o
);

    localparam int CNT_W = $clog2(DIV_B) + 1;

    smp_state_t       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] half;

    // Decode the selected oversampling ratio and its half-bit count.
    always_comb begin
        case (div_sel)
            2'b00:   ratio = CNT_W'(1);
            2'b01:   ratio = CNT_W'(DIV_A);
            default: ratio = CNT_W'(DIV_B);
        endcase
        half = ratio >> 1;
    end

    // State machine: idle -> qualify -> run, with the bit-phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            st_q  <= SMP_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                SMP_IDLE: begin
                    if (!rx_line) begin
                        if (half <= CNT_W'(1)) begin
                            st_q  <= SMP_RUN;
                            cnt_q <= '0;
                        end else begin
                            st_q  <= SMP_QUAL;
                            cnt_q <= CNT_W'(1);
                        end
                    end
                end
                SMP_QUAL: begin
                    if (rx_line) begin
                        st_q  <= SMP_IDLE;
                        cnt_q <= '0;
                    end else if (cnt_q + CNT_W'(1) == half) begin
                        st_q  <= SMP_RUN;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                SMP_RUN: begin
                    if (frame_done) begin
                        st_q  <= SMP_IDLE;
                        cnt_q <= '0;
                    end else if (cnt_q == ratio - CNT_W'(1)) begin
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    st_q  <= SMP_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    // Sample strobe at the end of each bit period measured from lock.
    assign tick_o = (st_q == SMP_RUN) && (cnt_q == ratio - CNT_W'(1));
    assign run_o  = (st_q == SMP_RUN);

    // R2
    qual_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SMP_QUAL) |-> !$past(rx_line));

    // R2
    lock_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == SMP_RUN) && ($past(st_q) != SMP_RUN)) |-> !$past(rx_line));

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && (div_sel != 2'b00) && !clear && !frame_done) |=> !tick_o);

endmodule

// File: rtl/rx_char_shifter.sv
// Module: rx_char_shifter
// Shifts in data and parity bits on each tick, LSB first, then judges the
// stop bit. Emits a one-cycle done pulse with data, framing and parity results.
// Assumes fmt_sel is stable while a character is in progress.
module rx_char_shifter
    import async_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [2:0]        fmt_sel,
    input  logic              run,
    input  logic              tick,
    input  logic              rx_line,
    output logic              done_o,
    output logic [CHAR_W-1:0] data_o,
    output logic              fe_o,
    output logic              pe_o
);

    logic [SHIFT_W-1:0] shreg_q;
    logic [3:0]         idx_q;
    logic [3:0]         nbits;
    logic               eight;
    logic               par_en;
    logic               par_bit;

    // Decode the format into payload length and parity position.
    always_comb begin
        eight   = fmt_eight(fmt_sel);
        par_en  = fmt_parity(fmt_sel);
        nbits   = (eight ? 4'd8 : 4'd7) + {3'b000, par_en};
        par_bit = eight ? shreg_q[8] : shreg_q[7];
    end

    // Bit position counter; rests at zero whenever no character is running.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run) begin
            idx_q <= '0;
        end else if (tick) begin
            idx_q <= idx_q + 4'd1;
        end
    end

    // Payload capture: store each sampled bit at its position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (run && tick && (idx_q < nbits)) begin
            shreg_q[idx_q] <= rx_line;
        end
    end

    // Results presented with the stop-bit tick.
    always_comb begin
        done_o = run && tick && (idx_q == nbits);
        data_o = eight ? shreg_q[7:0] : {1'b0, shreg_q[6:0]};
        fe_o   = !rx_line;
        pe_o   = par_en && ((^data_o) ^ par_bit ^ fmt_odd(fmt_sel));
    end

endmodule

// File: rtl/rx_hold_reg.sv
// Module: rx_hold_reg
// Single-entry data register with full flag, per-character error flags and
// a deferred overrun report. A flush clears all flags but keeps the data.
// Assumes data_rd is a one-cycle strobe.
module rx_hold_reg
    import async_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              done_in,
    input  logic [CHAR_W-1:0] data_in,
    input  logic              fe_in,
    input  logic              pe_in,
    input  logic              data_rd,
    output logic [CHAR_W-1:0] data_q,
    output logic              full_q,
    output logic              fe_q,
    output logic              pe_q,
    output logic              ovr_q
);

    logic pend_q;
    logic full_n, pend_n, ovr_n, load;

    // Next flag state: apply the read first, then the arriving character.
    always_comb begin
        full_n = full_q;
        pend_n = pend_q;
        ovr_n  = ovr_q;
        if (data_rd) begin
            if (ovr_q) begin
                ovr_n  = 1'b0;
                full_n = 1'b0;
            end else if (pend_q) begin
                ovr_n  = 1'b1;
                pend_n = 1'b0;
            end else begin
                full_n = 1'b0;
            end
        end
        load = 1'b0;
        if (done_in) begin
            if (!full_n) begin
                load   = 1'b1;
                full_n = 1'b1;
            end else if (!ovr_n) begin
                pend_n = 1'b1;
            end
        end
    end

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            full_q <= 1'b0;
            pend_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            full_q <= full_n;
            pend_q <= pend_n;
            ovr_q  <= ovr_n;
        end
    end

    // Error flags travel with the character that is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            fe_q <= 1'b0;
            pe_q <= 1'b0;
        end else if (load) begin
            fe_q <= fe_in;
            pe_q <= pe_in;
        end
    end

    // Data register, only written by a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load && !flush) begin
            data_q <= data_in;
        end
    end

    // R8
    load_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_q) |-> $past(done_in));

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_q) |-> !$past(full_q));

    // R9
    ovr_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(data_rd));

    // R9
    ovr_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |-> full_q);

    // R11
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!full_q && !ovr_q));

endmodule

// File: rtl/async_rx_engine.sv
// Module: async_rx_engine (top)
// Receive engine: bit sampler, character shifter and holding register.
// Carrier loss or the master-reset divider code flushes the whole receiver.
// Assumes all inputs are synchronous to the receive clock.
module async_rx_engine
    import async_rx_pkg::*;
#(
    parameter int DIV_A = 16,
    parameter int DIV_B = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    input  logic       carrier_lost,
    input  logic [1:0] div_sel,
    input  logic [2:0] fmt_sel,
    input  logic       data_rd,
    output logic [7:0] rx_data,
    output logic       rx_full,
    output logic       frame_err,
    output logic       parity_err,
    output logic       overrun
);

    logic              flush;
    logic              tick, run, done;
    logic [CHAR_W-1:0] sh_data;
    logic              sh_fe, sh_pe;

    // Receiver-wide initialize condition.
    assign flush = carrier_lost || (div_sel == 2'b11);

    rx_bit_sampler #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (flush),
        .div_sel    (div_sel),
        .rx_line    (rx_line),
        .frame_done (done),
        .tick_o     (tick),
        .run_o      (run)
    );

    rx_char_shifter u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (flush),
        .fmt_sel (fmt_sel),
        .run     (run),
        .tick    (tick),
        .rx_line (rx_line),
        .done_o  (done),
        .data_o  (sh_data),
        .fe_o    (sh_fe),
        .pe_o    (sh_pe)
    );

    rx_hold_reg u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .done_in (done),
        .data_in (sh_data),
        .fe_in   (sh_fe),
        .pe_in   (sh_pe),
        .data_rd (data_rd),
        .data_q  (rx_data),
        .full_q  (rx_full),
        .fe_q    (frame_err),
        .pe_q    (parity_err),
        .ovr_q   (overrun)
    );

endmodule

// File: tb/async_rx_engine_test.sv
module async_rx_engine_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       carrier_lost = 1'b0;
    logic [1:0] div_sel = 2'b01;
    logic [2:0] fmt_sel = 3'b101;
    logic       data_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, frame_err, parity_err, overrun;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    async_rx_engine uut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .carrier_lost(carrier_lost),
        .div_sel(div_sel), .fmt_sel(fmt_sel), .data_rd(data_rd),
        .rx_data(rx_data), .rx_full(rx_full), .frame_err(frame_err),
        .parity_err(parity_err), .overrun(overrun)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int ratio_of(input logic [1:0] d);
        return (d == 2'b00) ? 1 : (d == 2'b01) ? 16 : 64;
    endfunction

    // Send one character; stop_ok=0 drives a low stop just past its sample point.
    task automatic send_char(input logic [7:0] d, input logic bad_par, input logic stop_ok);
        int n;
        logic eight, par, pbit;
        n = ratio_of(div_sel);
        eight = fmt_sel[2];
        par = !(fmt_sel[2] && !fmt_sel[1]);
        pbit = (eight ? ^d : ^d[6:0]) ^ fmt_sel[0] ^ bad_par;
        rx_line = 1'b1;
        repeat (n + 3) @(negedge clk);
        rx_line = 1'b0;
        repeat (n) @(negedge clk);
        for (int i = 0; i < (eight ? 8 : 7); i++) begin
            rx_line = d[i];
            repeat (n) @(negedge clk);
        end
        if (par) begin
            rx_line = pbit;
            repeat (n) @(negedge clk);
        end
        rx_line = stop_ok;
        repeat (stop_ok ? n : (n / 2 + 1)) @(negedge clk);
        rx_line = 1'b1;
        repeat (n + 3) @(negedge clk);
    endtask

    task automatic read_pulse();
        @(negedge clk) data_rd = 1'b1;
        @(negedge clk) data_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 reset full", {7'b0, rx_full}, 8'h00);
        chk("R12 reset overrun", {7'b0, overrun}, 8'h00);
        chk("R12 reset fe", {7'b0, frame_err}, 8'h00);
        chk("R12 reset pe", {7'b0, parity_err}, 8'h00);
    endtask

    task automatic t_div16_basic();
        div_sel = 2'b01; fmt_sel = 3'b101;
        send_char(8'hA5, 1'b0, 1'b1);
        chk("R3 div16 data", rx_data, 8'hA5);
        chk("R8 full set", {7'b0, rx_full}, 8'h01);
        chk("R13 no parity pe", {7'b0, parity_err}, 8'h00);
        read_pulse();
        chk("R8 read clears full", {7'b0, rx_full}, 8'h00);
        chk("R8 read keeps data", rx_data, 8'hA5);
    endtask

    task automatic t_seven_bit();
        div_sel = 2'b01; fmt_sel = 3'b010;
        send_char(8'hD3, 1'b0, 1'b1);
        chk("R5 bit7 stripped", rx_data, 8'h53);
        chk("R4 even parity ok", {7'b0, parity_err}, 8'h00);
        read_pulse();
        fmt_sel = 3'b011;
        send_char(8'h2E, 1'b1, 1'b1);
        chk("R4 odd parity bad", {7'b0, parity_err}, 8'h01);
        chk("R7 pe held", {7'b0, parity_err}, 8'h01);
        read_pulse();
        chk("R7 pe stays with data", {7'b0, parity_err}, 8'h01);
        fmt_sel = 3'b001;
        send_char(8'h7F, 1'b0, 1'b1);
        chk("R4 7O2 data", rx_data, 8'h7F);
        chk("R7 pe updated on load", {7'b0, parity_err}, 8'h00);
        read_pulse();
    endtask

    task automatic t_eight_parity();
        div_sel = 2'b01; fmt_sel = 3'b110;
        send_char(8'h81, 1'b1, 1'b1);
        chk("R4 8E1 bad parity", {7'b0, parity_err}, 8'h01);
        read_pulse();
        fmt_sel = 3'b111;
        send_char(8'h81, 1'b0, 1'b1);
        chk("R4 8O1 data", rx_data, 8'h81);
        chk("R4 8O1 good parity", {7'b0, parity_err}, 8'h00);
        read_pulse();
    endtask

    task automatic t_framing();
        div_sel = 2'b01; fmt_sel = 3'b101;
        send_char(8'h3C, 1'b0, 1'b0);
        chk("R6 framing error", {7'b0, frame_err}, 8'h01);
        chk("R6 data", rx_data, 8'h3C);
        read_pulse();
        send_char(8'h11, 1'b0, 1'b1);
        chk("R7 fe cleared by next load", {7'b0, frame_err}, 8'h00);
        read_pulse();
    endtask

    task automatic t_false_start();
        div_sel = 2'b01; fmt_sel = 3'b101;
        @(negedge clk) rx_line = 1'b0;
        repeat (7) @(negedge clk);
        rx_line = 1'b1;
        repeat (250) @(negedge clk);
        chk("R2 false start dropped", {7'b0, rx_full}, 8'h00);
        send_char(8'h96, 1'b0, 1'b1);
        chk("R2 next char aligned", rx_data, 8'h96);
        read_pulse();
    endtask

    task automatic t_div64();
        div_sel = 2'b10; fmt_sel = 3'b101;
        send_char(8'h5A, 1'b0, 1'b1);
        chk("R3 div64 data", rx_data, 8'h5A);
        chk("R3 div64 full", {7'b0, rx_full}, 8'h01);
        read_pulse();
    endtask

    task automatic t_div1();
        div_sel = 2'b00; fmt_sel = 3'b101;
        send_char(8'hC3, 1'b0, 1'b1);
        chk("R1 div1 data", rx_data, 8'hC3);
        read_pulse();
        fmt_sel = 3'b000;
        send_char(8'h45, 1'b0, 1'b1);
        chk("R1 div1 7E2 data", rx_data, 8'h45);
        chk("R1 div1 pe", {7'b0, parity_err}, 8'h00);
        read_pulse();
    endtask

    task automatic t_overrun();
        div_sel = 2'b01; fmt_sel = 3'b101;
        send_char(8'h01, 1'b0, 1'b1);
        send_char(8'h02, 1'b0, 1'b1);
        chk("R9 overrun deferred", {7'b0, overrun}, 8'h00);
        chk("R9 old data kept", rx_data, 8'h01);
        read_pulse();
        chk("R9 overrun shown", {7'b0, overrun}, 8'h01);
        chk("R9 full stays", {7'b0, rx_full}, 8'h01);
        chk("R9 data still old", rx_data, 8'h01);
        read_pulse();
        chk("R10 overrun cleared", {7'b0, overrun}, 8'h00);
        chk("R10 full cleared", {7'b0, rx_full}, 8'h00);
        send_char(8'h03, 1'b0, 1'b1);
        chk("R10 sync kept", rx_data, 8'h03);
        read_pulse();
    endtask

    task automatic t_carrier();
        div_sel = 2'b01; fmt_sel = 3'b101;
        send_char(8'h44, 1'b0, 1'b1);
        @(negedge clk) carrier_lost = 1'b1;
        @(negedge clk);
        chk("R11 full reads empty", {7'b0, rx_full}, 8'h00);
        send_char(8'h55, 1'b0, 1'b1);
        chk("R11 no char while lost", {7'b0, rx_full}, 8'h00);
        chk("R11 data untouched", rx_data, 8'h44);
        @(negedge clk) carrier_lost = 1'b0;
        send_char(8'h66, 1'b0, 1'b1);
        chk("R11 resumes", rx_data, 8'h66);
        read_pulse();
    endtask

    task automatic t_master_reset();
        div_sel = 2'b01; fmt_sel = 3'b101;
        send_char(8'h0A, 1'b0, 1'b0);
        send_char(8'h0B, 1'b0, 1'b1);
        read_pulse();
        chk("R9 pre-reset overrun", {7'b0, overrun}, 8'h01);
        @(negedge clk) div_sel = 2'b11;
        @(negedge clk) div_sel = 2'b01;
        chk("R12 master reset overrun", {7'b0, overrun}, 8'h00);
        chk("R10 master reset full", {7'b0, rx_full}, 8'h00);
        chk("R12 master reset fe", {7'b0, frame_err}, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_div16_basic();
        t_seven_bit();
        t_eight_parity();
        t_framing();
        t_false_start();
        t_div64();
        t_div1();
        t_overrun();
        t_carrier();
        t_master_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule